// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block sits beside the bus logic of a two-port bridge and decides, for each I/O or memory transaction, whether the bridge claims it and passes it across, and in which direction. It keeps a small set of configuration registers loaded through a simple write port: three enable bits and a legacy-ISA bit, one I/O window and two memory windows (non-prefetchable and prefetchable). An external VGA decoder reports through one input whether a memory address belongs to the legacy display range. The block does not decode that range itself.

Each request carries an address, a 3-bit command and the bus it came from (primary or secondary). One clock later the block presents a registered verdict: forward or ignore, whether the forward goes upstream, and whether the target may be prefetched. A two-state machine sequences this. `ST_IDLE` moves to `ST_RESULT` on a valid request. `ST_RESULT` stays in `ST_RESULT` while requests keep arriving every cycle and returns to `ST_IDLE` when one does not. `dec_valid` is high exactly in `ST_RESULT`.

Top module: `fwd_decoder`

## Requirements
- R1: After reset the I/O, memory, master and ISA bits are 0. Every window base is all ones and every limit all zeros. `dec_valid` is 0 and no transaction is forwarded until software enables something.
- R2: A request sampled with `req_valid` high at a clock edge gives `dec_valid` high after that edge, with its verdict on `dec_fwd`, `dec_upstream` and `dec_prefetch`. An edge without a request gives `dec_valid` low and all verdict bits 0.
- R3: A write with `cfg_we` high loads the register named by `cfg_sel`. Selector 0 is control: bit0 I/O enable, bit1 memory enable, bit2 master enable, bit3 ISA enable. Selectors 1 and 2 are the I/O base and limit (data bits [3:0]). Selectors 3 and 4 are the non-prefetchable base and limit (data bits [11:0]). Selectors 5 and 6 are the prefetchable base and limit. A request sampled at the same edge as a write is decided with the old register values.
- R4: A primary I/O request is forwarded downstream when I/O enable is 1, the address is inside the I/O window and it is not in the ISA hole.
- R5: A secondary I/O request is forwarded upstream when master enable is 1 and the address is either outside the I/O window or in the ISA hole.
- R6: The ISA hole is active only when ISA enable is 1. It covers an address with bits [31:16] zero and bits [9:8] not equal to 00.
- R7: A primary memory request is forwarded downstream when memory enable is 1 and the address is inside the non-prefetchable window, inside the prefetchable window, or flagged by `req_vga_hit`.
- R8: A secondary memory request is forwarded upstream when master enable is 1, the address is in neither memory window and `req_vga_hit` is 0. Otherwise it is ignored.
- R9: A memory window hits when base <= addr[31:20] <= limit, which spans base<<20 through (limit<<20)|0xFFFFF. The I/O window hits when addr[31:16] is 0 and base <= addr[15:12] <= limit. A window whose base exceeds its limit never hits.
- R10: `dec_prefetch` is 1 only for a forwarded memory read. The memory read commands are 2, 4 and 5. It is 1 when the address is in the prefetchable window, or when the command is read-line (4) or read-multiple (5). A plain read (2) outside the prefetchable window gets 0.
- R11: The command encoding is 0 I/O read, 1 I/O write, 2 memory read, 3 memory write, 4 memory read line and 5 memory read multiple. Codes 6 and 7 are never forwarded. `dec_upstream` is 1 only for a forwarded secondary-side request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 12 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Transaction address |
| req_cmd | input | 3 | Command code |
| req_from_sec | input | 1 | 1 = request originated on the secondary bus |
| req_vga_hit | input | 1 | External VGA decoder claims this memory address |
| dec_valid | output | 1 | Verdict valid |
| dec_fwd | output | 1 | Forward the transaction |
| dec_upstream | output | 1 | The forward goes from secondary to primary |
| dec_prefetch | output | 1 | Prefetching allowed |

## Verification
A register write and a request can land on the same clock edge. The request must then see the configuration from before the write. The bench provokes this by driving a write that flips a window or enable bit in the same cycle as a request whose verdict depends on that bit. It judges the result against a model that is updated only after the expected value has been computed. Back-to-back requests also exercise the `ST_RESULT` self-loop, and they are interleaved with idle cycles to cover the return to `ST_IDLE`.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [2:0] {
        CMD_IO_RD      = 3'd0,
        CMD_IO_WR      = 3'd1,
        CMD_MEM_RD     = 3'd2,
        CMD_MEM_WR     = 3'd3,
        CMD_MEM_RDLINE = 3'd4,
        CMD_MEM_RDMULT = 3'd5,
        CMD_RSVD6      = 3'd6,
        CMD_RSVD7      = 3'd7
    } fwd_cmd_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fwd_state_e;

    localparam logic [2:0] SEL_CTRL     = 3'd0;
    localparam logic [2:0] SEL_IO_BASE  = 3'd1;
    localparam logic [2:0] SEL_IO_LIMIT = 3'd2;
    localparam logic [2:0] SEL_NP_BASE  = 3'd3;
    localparam logic [2:0] SEL_NP_LIMIT = 3'd4;
    localparam logic [2:0] SEL_PF_BASE  = 3'd5;
    localparam logic [2:0] SEL_PF_LIMIT = 3'd6;

    localparam int CTRL_IO_EN     = 0;
    localparam int CTRL_MEM_EN    = 1;
    localparam int CTRL_MASTER_EN = 2;
    localparam int CTRL_ISA_EN    = 3;

    localparam int WIN_NP = 0;
    localparam int WIN_PF = 1;
    localparam int NUM_MEM_WIN = 2;

endpackage

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs
    import fwd_pkg::*;
#(
    parameter int IO_FIELD_W  = 4,
    parameter int MEM_FIELD_W = 12
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      we,
    input  logic [2:0]                                sel,
    input  logic [MEM_FIELD_W-1:0]                    wdata,
    output logic                                      io_en,
    output logic                                      mem_en,
    output logic                                      master_en,
    output logic                                      isa_en,
    output logic [IO_FIELD_W-1:0]                     io_base,
    output logic [IO_FIELD_W-1:0]                     io_limit,
    output logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]   mem_base,
    output logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]   mem_limit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_en     <= 1'b0;
            mem_en    <= 1'b0;
            master_en <= 1'b0;
            isa_en    <= 1'b0;
            io_base   <= '1;
            io_limit  <= '0;
            mem_base  <= '1;
            mem_limit <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_CTRL: begin
                    io_en     <= wdata[CTRL_IO_EN];
                    mem_en    <= wdata[CTRL_MEM_EN];
                    master_en <= wdata[CTRL_MASTER_EN];
                    isa_en    <= wdata[CTRL_ISA_EN];
                end
                SEL_IO_BASE:  io_base  <= wdata[IO_FIELD_W-1:0];
                SEL_IO_LIMIT: io_limit <= wdata[IO_FIELD_W-1:0];
                SEL_NP_BASE:  mem_base[WIN_NP]  <= wdata;
                SEL_NP_LIMIT: mem_limit[WIN_NP] <= wdata;
                SEL_PF_BASE:  mem_base[WIN_PF]  <= wdata;
                SEL_PF_LIMIT: mem_limit[WIN_PF] <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fwd_window.sv
module fwd_window #(
    parameter int FIELD_W = 12
) (
    input  logic               in_space,
    input  logic [FIELD_W-1:0] field,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] limit,
    output logic               hit
);

    logic above_base;
    logic below_limit;

    always_comb begin
        above_base  = (field >= base);
        below_limit = (field <= limit);
        hit         = in_space && above_base && below_limit;
    end

endmodule

// File: rtl/fwd_rule.sv
module fwd_rule
    import fwd_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int MEM_GRAN_BITS  = 20,
    parameter int IO_GRAN_BITS   = 12,
    parameter int IO_SPACE_BITS  = 16,
    parameter int ISA_BLOCK_BITS = 10,
    localparam int MEM_FIELD_W   = ADDR_W - MEM_GRAN_BITS,
    localparam int IO_FIELD_W    = IO_SPACE_BITS - IO_GRAN_BITS
) (
    input  logic [ADDR_W-1:0]                         addr,
    input  fwd_cmd_e                                  cmd,
    input  logic                                      from_sec,
    input  logic                                      vga_hit,
    input  logic                                      io_en,
    input  logic                                      mem_en,
    input  logic                                      master_en,
    input  logic                                      isa_en,
    input  logic [IO_FIELD_W-1:0]                     io_base,
    input  logic [IO_FIELD_W-1:0]                     io_limit,
    input  logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]   mem_base,
    input  logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]   mem_limit,
    output logic                                      fwd,
    output logic                                      upstream,
    output logic                                      prefetch
);

    logic                   io_space;
    logic                   io_hit;
    logic [NUM_MEM_WIN-1:0] mem_hit;
    logic                   isa_hole;
    logic                   is_io;
    logic                   is_mem;
    logic                   is_rd;
    logic                   is_burst_rd;
    logic                   any_mem_hit;

    assign io_space = (addr[ADDR_W-1:IO_SPACE_BITS] == '0);

    fwd_window #(.FIELD_W(IO_FIELD_W)) u_io_win (
        .in_space (io_space),
        .field    (addr[IO_SPACE_BITS-1:IO_GRAN_BITS]),
        .base     (io_base),
        .limit    (io_limit),
        .hit      (io_hit)
    );

    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem_win
        fwd_window #(.FIELD_W(MEM_FIELD_W)) u_mem_win (
            .in_space (1'b1),
            .field    (addr[ADDR_W-1:MEM_GRAN_BITS]),
            .base     (mem_base[w]),
            .limit    (mem_limit[w]),
            .hit      (mem_hit[w])
        );
    end

    always_comb begin
        isa_hole    = isa_en && io_space &&
                      (addr[ISA_BLOCK_BITS-1:ISA_BLOCK_BITS-2] != 2'b00);
        any_mem_hit = |mem_hit;
        is_io       = 1'b0;
        is_mem      = 1'b0;
        is_rd       = 1'b0;
        is_burst_rd = 1'b0;
        unique case (cmd)
            CMD_IO_RD, CMD_IO_WR: is_io = 1'b1;
            CMD_MEM_RD: begin
                is_mem = 1'b1;
                is_rd  = 1'b1;
            end
            CMD_MEM_WR: is_mem = 1'b1;
            CMD_MEM_RDLINE, CMD_MEM_RDMULT: begin
                is_mem      = 1'b1;
                is_rd       = 1'b1;
                is_burst_rd = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        fwd = 1'b0;
        if (is_io) begin
            if (from_sec) fwd = master_en && (isa_hole || !io_hit);
            else          fwd = io_en && io_hit && !isa_hole;
        end else if (is_mem) begin
            if (from_sec) fwd = master_en && !any_mem_hit && !vga_hit;
            else          fwd = mem_en && (any_mem_hit || vga_hit);
        end
        upstream = fwd && from_sec;
        prefetch = fwd && is_rd && (mem_hit[WIN_PF] || is_burst_rd);
    end

endmodule

// File: rtl/fwd_decoder.sv
module fwd_decoder
    import fwd_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int MEM_GRAN_BITS  = 20,
    parameter int IO_GRAN_BITS   = 12,
    parameter int IO_SPACE_BITS  = 16,
    parameter int ISA_BLOCK_BITS = 10,
    localparam int MEM_FIELD_W   = ADDR_W - MEM_GRAN_BITS,
    localparam int IO_FIELD_W    = IO_SPACE_BITS - IO_GRAN_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_sel,
    input  logic [MEM_FIELD_W-1:0] cfg_wdata,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2:0]             req_cmd,
    input  logic                   req_from_sec,
    input  logic                   req_vga_hit,
    output logic                   dec_valid,
    output logic                   dec_fwd,
    output logic                   dec_upstream,
    output logic                   dec_prefetch
);

    logic                                    io_en, mem_en, master_en, isa_en;
    logic [IO_FIELD_W-1:0]                   io_base, io_limit;
    logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_base, mem_limit;
    logic                                    rule_fwd, rule_up, rule_pf;
    fwd_state_e                              state_q, state_d;

    fwd_cfg_regs #(.IO_FIELD_W(IO_FIELD_W), .MEM_FIELD_W(MEM_FIELD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .master_en (master_en),
        .isa_en    (isa_en),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .mem_base  (mem_base),
        .mem_limit (mem_limit)
    );

    fwd_rule #(
        .ADDR_W         (ADDR_W),
        .MEM_GRAN_BITS  (MEM_GRAN_BITS),
        .IO_GRAN_BITS   (IO_GRAN_BITS),
        .IO_SPACE_BITS  (IO_SPACE_BITS),
        .ISA_BLOCK_BITS (ISA_BLOCK_BITS)
    ) u_rule (
        .addr      (req_addr),
        .cmd       (fwd_cmd_e'(req_cmd)),
        .from_sec  (req_from_sec),
        .vga_hit   (req_vga_hit),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .master_en (master_en),
        .isa_en    (isa_en),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .mem_base  (mem_base),
        .mem_limit (mem_limit),
        .fwd       (rule_fwd),
        .upstream  (rule_up),
        .prefetch  (rule_pf)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output process: verdict captured with the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_fwd      <= 1'b0;
            dec_upstream <= 1'b0;
            dec_prefetch <= 1'b0;
        end else if (req_valid) begin
            dec_fwd      <= rule_fwd;
            dec_upstream <= rule_up;
            dec_prefetch <= rule_pf;
        end else begin
            dec_fwd      <= 1'b0;
            dec_upstream <= 1'b0;
            dec_prefetch <= 1'b0;
        end
    end

    assign dec_valid = (state_q == ST_RESULT);

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_fwd && !dec_prefetch));

    // R5 and R8: no upstream forward without master enable
    assert_up_needs_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_upstream) |-> $past(master_en));

    assert_down_mem_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_fwd && !dec_upstream && ($past(req_cmd) >= 3'd2)) |-> $past(mem_en));

    assert_prefetch_only_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_prefetch |-> (dec_valid && dec_fwd));

    assert_upstream_from_sec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_upstream |-> (dec_fwd && $past(req_from_sec)));

    assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd[2] && req_cmd[1]) |=> !dec_fwd);

endmodule

// File: tb/tb_fwd_decoder.sv
module tb_fwd_decoder;
    import fwd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [11:0] cfg_wdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [2:0]  req_cmd;
    logic        req_from_sec;
    logic        req_vga_hit;
    logic        dec_valid, dec_fwd, dec_upstream, dec_prefetch;

    always #2 clk = ~clk;

    fwd_decoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_cmd      (req_cmd),
        .req_from_sec (req_from_sec),
        .req_vga_hit  (req_vga_hit),
        .dec_valid    (dec_valid),
        .dec_fwd      (dec_fwd),
        .dec_upstream (dec_upstream),
        .dec_prefetch (dec_prefetch)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        m_io_en, m_mem_en, m_master, m_isa;
    logic [3:0]  m_io_base, m_io_limit;
    logic [11:0] m_np_base, m_np_limit, m_pf_base, m_pf_limit;

    function automatic logic [2:0] ref_dec(input logic [31:0] a, input logic [2:0] c,
                                           input logic sec, input logic vga);
        logic io_sp, in_io, hole, in_np, in_pf, f, p;
        io_sp = (a[31:16] == 16'h0);
        in_io = io_sp && (m_io_base <= a[15:12]) && (a[15:12] <= m_io_limit);
        hole  = m_isa && io_sp && (a[9:8] != 2'b00);
        in_np = (m_np_base <= a[31:20]) && (a[31:20] <= m_np_limit);
        in_pf = (m_pf_base <= a[31:20]) && (a[31:20] <= m_pf_limit);
        f = 1'b0;
        if (c <= 3'd1) f = sec ? (m_master && (hole || !in_io)) : (m_io_en && in_io && !hole);
        else if (c <= 3'd5) f = sec ? (m_master && !in_np && !in_pf && !vga)
                                    : (m_mem_en && (in_np || in_pf || vga));
        p = f && (c == 3'd2 || c == 3'd4 || c == 3'd5) && (in_pf || c == 3'd4 || c == 3'd5);
        return {f, f && sec, p};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] s, input logic [11:0] d);
        case (s)
            SEL_CTRL: begin
                m_io_en = d[0]; m_mem_en = d[1]; m_master = d[2]; m_isa = d[3];
            end
            SEL_IO_BASE:  m_io_base  = d[3:0];
            SEL_IO_LIMIT: m_io_limit = d[3:0];
            SEL_NP_BASE:  m_np_base  = d;
            SEL_NP_LIMIT: m_np_limit = d;
            SEL_PF_BASE:  m_pf_base  = d;
            SEL_PF_LIMIT: m_pf_limit = d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] s, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model_write(s, d);
    endtask

    // Request, optionally with a register write at the same edge
    task automatic req(input string tag, input logic [31:0] a, input logic [2:0] c,
                       input logic sec, input logic vga,
                       input logic do_wr, input logic [2:0] s, input logic [11:0] d);
        logic [2:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_from_sec = sec; req_vga_hit = vga;
        cfg_we = do_wr; cfg_sel = s; cfg_wdata = d;
        exp = ref_dec(a, c, sec, vga);
        @(posedge clk); #1;
        req_valid = 1'b0; cfg_we = 1'b0;
        if (do_wr) model_write(s, d);
        chk({tag, " valid"}, {31'd0, dec_valid}, 32'd1);
        chk(tag, {29'd0, dec_fwd, dec_upstream, dec_prefetch}, {29'd0, exp});
    endtask

    task automatic rq(input string tag, input logic [31:0] a, input logic [2:0] c,
                      input logic sec, input logic vga);
        req(tag, a, c, sec, vga, 1'b0, 3'd0, 12'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'h5EED_0042);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_from_sec = 1'b0; req_vga_hit = 1'b0;
        m_io_en = 0; m_mem_en = 0; m_master = 0; m_isa = 0;
        m_io_base = 4'hF; m_io_limit = 4'h0;
        m_np_base = 12'hFFF; m_np_limit = 12'h0; m_pf_base = 12'hFFF; m_pf_limit = 12'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", {31'd0, dec_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R2 idle after reset", {28'd0, dec_valid, dec_fwd, dec_upstream, dec_prefetch}, 32'd0);

        // R1: nothing forwarded with reset configuration
        rq("R1 pri io",  32'h0000_1000, 3'd0, 1'b0, 1'b0);
        rq("R1 sec io",  32'h0000_1000, 3'd1, 1'b1, 1'b0);
        rq("R1 pri mem", 32'h0030_0000, 3'd2, 1'b0, 1'b1);
        rq("R1 sec mem", 32'h0030_0000, 3'd3, 1'b1, 1'b0);

        // R4 R5 R6: I/O window 0x0000-0x0FFF with ISA hole
        wr(SEL_IO_BASE, 12'h0);
        wr(SEL_IO_LIMIT, 12'h0);
        wr(SEL_CTRL, 12'b1101);
        rq("R4 pri io low 256",    32'h0000_0050, 3'd0, 1'b0, 1'b0);
        rq("R6 pri io hole",       32'h0000_0150, 3'd0, 1'b0, 1'b0);
        rq("R5 sec io hole",       32'h0000_0350, 3'd1, 1'b1, 1'b0);
        rq("R5 sec io in window",  32'h0000_0050, 3'd1, 1'b1, 1'b0);
        rq("R6 sec io above 64K",  32'h0001_0150, 3'd1, 1'b1, 1'b0);
        rq("R5 sec io outside",    32'h0000_2050, 3'd0, 1'b1, 1'b0);
        wr(SEL_CTRL, 12'b0101);
        rq("R6 isa off pri",       32'h0000_0150, 3'd0, 1'b0, 1'b0);
        rq("R6 isa off sec",       32'h0000_0150, 3'd0, 1'b1, 1'b0);
        wr(SEL_CTRL, 12'b1001);
        rq("R5 master off",        32'h0000_0350, 3'd1, 1'b1, 1'b0);

        // R9 R7 R8 R10: non-prefetchable 0x0020_0000-0x003F_FFFF, prefetchable 0x0100_0000-0x010F_FFFF
        wr(SEL_NP_BASE, 12'h002);
        wr(SEL_NP_LIMIT, 12'h003);
        wr(SEL_PF_BASE, 12'h010);
        wr(SEL_PF_LIMIT, 12'h010);
        wr(SEL_CTRL, 12'b0110);
        rq("R9 below np",          32'h001F_FFFF, 3'd3, 1'b0, 1'b0);
        rq("R9 np lower edge",     32'h0020_0000, 3'd3, 1'b0, 1'b0);
        rq("R9 np upper edge",     32'h003F_FFFF, 3'd3, 1'b0, 1'b0);
        rq("R9 above np",          32'h0040_0000, 3'd3, 1'b0, 1'b0);
        rq("R10 np plain read",    32'h0020_0040, 3'd2, 1'b0, 1'b0);
        rq("R10 np read line",     32'h0020_0040, 3'd4, 1'b0, 1'b0);
        rq("R10 np read mult",     32'h0030_0040, 3'd5, 1'b0, 1'b0);
        rq("R10 pf plain read",    32'h0100_0000, 3'd2, 1'b0, 1'b0);
        rq("R7 vga down",          32'h000A_0000, 3'd2, 1'b0, 1'b1);
        rq("R8 sec in np",         32'h0020_0000, 3'd3, 1'b1, 1'b0);
        rq("R8 sec in pf",         32'h0100_0000, 3'd3, 1'b1, 1'b0);
        rq("R8 sec vga",           32'h000A_0000, 3'd3, 1'b1, 1'b1);
        rq("R8 sec outside",       32'h0800_0000, 3'd2, 1'b1, 1'b0);
        rq("R11 reserved 6",       32'h0020_0000, 3'd6, 1'b0, 1'b0);
        rq("R11 reserved 7",       32'h0800_0000, 3'd7, 1'b1, 1'b0);
        wr(SEL_CTRL, 12'b0100);
        rq("R7 mem enable off",    32'h0020_0000, 3'd3, 1'b0, 1'b0);

        // R3: write and request on the same edge use the old values
        req("R3 same edge np base", 32'h0020_0000, 3'd3, 1'b1, 1'b0, 1'b1, SEL_NP_BASE, 12'h800);
        rq("R3 after np write",     32'h0020_0000, 3'd3, 1'b1, 1'b0);
        req("R3 same edge ctrl",    32'h0800_0000, 3'd3, 1'b1, 1'b0, 1'b1, SEL_CTRL, 12'b0000);
        rq("R3 after ctrl write",   32'h0800_0000, 3'd3, 1'b1, 1'b0);
        wr(SEL_IO_BASE, 12'h3);
        wr(SEL_IO_LIMIT, 12'h2);
        wr(SEL_CTRL, 12'b0001);
        rq("R9 io window disabled", 32'h0000_2000, 3'd0, 1'b0, 1'b0);

        // Random configurations, back-to-back and gapped requests
        for (int round = 0; round < 40; round++) begin
            wr(SEL_CTRL,     12'($urandom_range(0, 15)));
            wr(SEL_IO_BASE,  12'($urandom_range(0, 15)));
            wr(SEL_IO_LIMIT, 12'($urandom_range(0, 15)));
            wr(SEL_NP_BASE,  12'($urandom_range(0, 15)));
            wr(SEL_NP_LIMIT, 12'($urandom_range(0, 15)));
            wr(SEL_PF_BASE,  12'($urandom_range(0, 15)));
            wr(SEL_PF_LIMIT, 12'($urandom_range(0, 15)));
            for (int k = 0; k < 60; k++) begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom_range(0, 1) == 0) a[31:16] = ($urandom_range(0, 7) == 0) ? 16'h1 : 16'h0;
                else a[31:20] = 12'($urandom_range(0, 17));
                rq("R4 R5 R7 R8 R10 random", a, 3'($urandom_range(0, 7)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
                if ($urandom_range(0, 3) == 0) begin
                    @(posedge clk); #1;
                    chk("R2 gap cycle", {28'd0, dec_valid, dec_fwd, dec_upstream, dec_prefetch}, 32'd0);
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule